// File: doc/BRIEF.md
# UART Receive Wake-Up Monitor

This block sits beside an asynchronous serial receiver and lets activity on the receive line wake a sleeping system while the baud clock is stopped. Software arms the monitor by writing a one to the arm bit. While the arm bit is set, the gating output holds the normal receive state machine idle, and the monitor waits for the line to go low.

A falling edge on the line while armed is the wake event. It raises the receive interrupt flag. When the system clock runs, the edge passes through a synchronizer and the flag is set on a clock edge. In sleep, an edge-clocked toggle captures the falling edge with no clock at all, and the flag output rises at once. The capture is resynchronized when the clock returns.

After the wake event, the monitor waits for the line to rise again, which marks the end of the break. That rising edge clears the arm bit by itself and releases the receiver. Reading the receive buffer clears the interrupt flag.

Top module: `uart_wake_detect`

## Requirements
- R1: After reset, rxIntFlag, armBit, rxSuppress and breakWait are all 0.
- R2: A pulse on armWr loads armBit from armWrData on the next clock edge, and rxSuppress always equals armBit.
- R3: While armed, awake (sleepMode=0) and not yet in breakWait, a falling edge on rxIn sets rxIntFlag and breakWait on the third clock edge after the change, and on neither earlier edge.
- R4: A falling edge on rxIn while armBit is 0 sets neither rxIntFlag nor breakWait.
- R5: While breakWait is 1, a rising edge on rxIn clears armBit, rxSuppress and breakWait on the third clock edge after the change.
- R6: A one-cycle bufRead pulse clears rxIntFlag on the next clock edge.
- R7: If bufRead is high in the same cycle that a wake event sets the flag, the flag ends up set.
- R8: A software write of 0 to the arm bit while breakWait is 1 clears armBit, rxSuppress and breakWait on the next clock edge.
- R9: With sleepMode=1 and the clock stopped, a falling edge on rxIn while armed drives rxIntFlag high without any clock edge. Once the clock resumes, breakWait becomes 1 within three edges and rxIntFlag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; may be stopped in sleep |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Raw receive line, idle high |
| sleepMode | input | 1 | High while the system sleeps |
| armWr | input | 1 | One-cycle write strobe for the arm bit |
| armWrData | input | 1 | Value written to the arm bit |
| bufRead | input | 1 | Receive-buffer read strobe; clears the flag |
| rxIntFlag | output | 1 | Receive interrupt flag |
| armBit | output | 1 | Current value of the arm bit |
| rxSuppress | output | 1 | Holds the normal receiver idle while high |
| breakWait | output | 1 | Falling edge seen, rising edge not yet seen |

## Verification
Each result is due a fixed number of clock edges after its stimulus:
- Software writes and buffer reads take effect on the first edge.
- A line edge takes effect on the third edge: two synchronizer stages, then the state register.
- The sleep-mode flag responds combinationally, with no edge at all.

The bench drives inputs one nanosecond after a falling clock edge. A behavioural model keeps the history of the line and of the sleep capture in queues and predicts every output. The outputs are compared at each falling clock edge. Directed checks sample once at the edge before the due edge, to show the flag is not early, and once at the due edge. While the clock is stopped, the sleep case is checked by time delay alone.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ARMED = 2'd1,
    WK_BREAK = 2'd2
  } wakeState_t;

  // control -> datapath
  typedef struct packed {
    logic raiseInt;
    logic clearInt;
    logic listenAsync;
  } wakeStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic fallSeen;
    logic riseSeen;
    logic asyncHit;
  } lineEvent_t;

endpackage

// File: rtl/uart_wake_datapath.sv
module uart_wake_datapath
  import uart_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxIn,
  input  logic        sleepMode,
  input  wakeStrobe_t strobe,
  output lineEvent_t  events,
  output logic        intFlag
);

  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] rxPipe;
  logic [LAST:0] togPipe;
  logic          asyncTog;
  logic          intReg;

  // Clockless capture: toggles on a falling line edge while armed in sleep
  always_ff @(negedge rxIn or negedge rstN) begin
    if (!rstN)                                asyncTog <= 1'b0;
    else if (sleepMode && strobe.listenAsync) asyncTog <= ~asyncTog;
  end

  // Synchronizer stages plus one history stage for edge detection
  for (genvar i = 0; i <= LAST; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rxPipe[i]  <= 1'b1;
          togPipe[i] <= 1'b0;
        end else begin
          rxPipe[i]  <= rxIn;
          togPipe[i] <= asyncTog;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rxPipe[i]  <= 1'b1;
          togPipe[i] <= 1'b0;
        end else begin
          rxPipe[i]  <= rxPipe[i-1];
          togPipe[i] <= togPipe[i-1];
        end
      end
    end
  end

  always_comb begin
    events.fallSeen = rxPipe[LAST] & ~rxPipe[LAST-1] & ~sleepMode;
    events.riseSeen = ~rxPipe[LAST] & rxPipe[LAST-1];
    events.asyncHit = togPipe[LAST] ^ togPipe[LAST-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                intReg <= 1'b0;
    else if (strobe.raiseInt) intReg <= 1'b1;
    else if (strobe.clearInt) intReg <= 1'b0;
  end

  // Unsynchronized pending capture shows up at once while the clock is stopped
  assign intFlag = intReg | (asyncTog ^ togPipe[LAST]);

  assert_raise_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raiseInt |=> intReg);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearInt && !strobe.raiseInt) |=> !intReg);

endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
  import uart_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armWr,
  input  logic        armWrData,
  input  logic        bufRead,
  input  lineEvent_t  events,
  output wakeStrobe_t strobe,
  output logic        armBit,
  output logic        breakWait
);

  wakeState_t state, stateNext;
  logic       wakeEvent;

  assign wakeEvent = (state == WK_ARMED) && !armWr &&
                     (events.fallSeen || events.asyncHit);

  always_comb begin
    stateNext = state;
    if (armWr)
      stateNext = armWrData ? WK_ARMED : WK_IDLE;
    else if (wakeEvent)
      stateNext = WK_BREAK;
    else if (state == WK_BREAK && events.riseSeen)
      stateNext = WK_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WK_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.raiseInt    = wakeEvent;
    strobe.clearInt    = bufRead;
    strobe.listenAsync = (state == WK_ARMED);
  end

  assign armBit    = (state != WK_IDLE);
  assign breakWait = (state == WK_BREAK);

  assert_wake_enters_break_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == WK_ARMED && !armWr && events.fallSeen) |=> (state == WK_BREAK));

  assert_idle_ignores_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == WK_IDLE && !armWr) |=> (state != WK_BREAK));

  assert_rise_disarms_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == WK_BREAK && events.riseSeen && !armWr) |=> (state == WK_IDLE));

  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armWr && !armWrData) |=> (state == WK_IDLE));

endmodule

// File: rtl/uart_wake_detect.sv
module uart_wake_detect
  import uart_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  input  logic sleepMode,
  input  logic armWr,
  input  logic armWrData,
  input  logic bufRead,
  output logic rxIntFlag,
  output logic armBit,
  output logic rxSuppress,
  output logic breakWait
);

  wakeStrobe_t strobe;
  lineEvent_t  events;

  uart_wake_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .armWr     (armWr),
    .armWrData (armWrData),
    .bufRead   (bufRead),
    .events    (events),
    .strobe    (strobe),
    .armBit    (armBit),
    .breakWait (breakWait)
  );

  uart_wake_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .sleepMode (sleepMode),
    .strobe    (strobe),
    .events    (events),
    .intFlag   (rxIntFlag)
  );

  assign rxSuppress = armBit;

  assert_suppress_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armWr && armWrData) |=> (armBit && rxSuppress));

endmodule

// File: tb/uart_wake_detect_test.sv
module uart_wake_detect_test;

  logic clkRaw = 1'b0;
  logic clkRun = 1'b1;
  logic clk;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic sleepMode = 1'b0;
  logic armWr = 1'b0;
  logic armWrData = 1'b0;
  logic bufRead = 1'b0;
  logic rxIntFlag, armBit, rxSuppress, breakWait;

  always #2 clkRaw = ~clkRaw;
  assign clk = clkRaw & clkRun;

  uart_wake_detect uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sleepMode(sleepMode),
    .armWr(armWr), .armWrData(armWrData), .bufRead(bufRead),
    .rxIntFlag(rxIntFlag), .armBit(armBit), .rxSuppress(rxSuppress),
    .breakWait(breakWait)
  );

  int    nCompared = 0;
  int    nMismatch = 0;
  string curReq = "R1";
  bit    compareOn = 1'b0;
  bit    finished = 1'b0;

  // Behavioural reference model
  bit mArm = 0, mWait = 0, mFlag = 0, mTog = 0;
  bit rxQ[$]  = '{1'b1, 1'b1, 1'b1};
  bit togQ[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk) begin
    if (!rstN) begin
      mArm = 0; mWait = 0; mFlag = 0;
      rxQ = '{1'b1, 1'b1, 1'b1};
      togQ = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit fall, rise, hit, wake;
      fall = rxQ[0] && !rxQ[1] && !sleepMode;
      rise = !rxQ[0] && rxQ[1];
      hit  = togQ[0] != togQ[1];
      wake = mArm && !mWait && !armWr && (fall || hit);
      if (armWr) begin mArm = armWrData; mWait = 0; end
      else if (wake) mWait = 1;
      else if (mWait && rise) begin mArm = 0; mWait = 0; end
      if (wake) mFlag = 1;
      else if (bufRead) mFlag = 0;
      rxQ.push_back(rxIn);   void'(rxQ.pop_front());
      togQ.push_back(mTog);  void'(togQ.pop_front());
    end
  end

  always @(negedge rxIn or negedge rstN) begin
    if (!rstN) mTog = 0;
    else if (sleepMode && mArm && !mWait) mTog = ~mTog;
  end

  task automatic check(string req, string what, logic act, logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && compareOn) begin
      check(curReq, "rxIntFlag", rxIntFlag, mFlag | (mTog ^ togQ[0]));
      check(curReq, "armBit", armBit, mArm);
      check(curReq, "rxSuppress", rxSuppress, mArm);
      check(curReq, "breakWait", breakWait, mWait);
    end
  end

  task automatic cycles(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic writeArm(bit v);
    armWr = 1'b1; armWrData = v;
    cycles(1);
    armWr = 1'b0;
  endtask

  task automatic readBuf();
    bufRead = 1'b1;
    cycles(1);
    bufRead = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nMismatch++; nCompared++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1", "rxIntFlag", rxIntFlag, 1'b0);
    check("R1", "armBit", armBit, 1'b0);
    check("R1", "rxSuppress", rxSuppress, 1'b0);
    check("R1", "breakWait", breakWait, 1'b0);
    compareOn = 1'b1;

    // R4 falling edge while disarmed
    curReq = "R4";
    rxIn = 1'b0; cycles(5);
    check("R4", "rxIntFlag", rxIntFlag, 1'b0);
    check("R4", "breakWait", breakWait, 1'b0);
    rxIn = 1'b1; cycles(4);

    // R2 arm write
    curReq = "R2";
    writeArm(1'b1);
    check("R2", "armBit", armBit, 1'b1);
    check("R2", "rxSuppress", rxSuppress, 1'b1);
    cycles(2);

    // R3 wake edge: due on the third edge
    curReq = "R3";
    rxIn = 1'b0; cycles(2);
    check("R3", "rxIntFlag early", rxIntFlag, 1'b0);
    cycles(1);
    check("R3", "rxIntFlag", rxIntFlag, 1'b1);
    check("R3", "breakWait", breakWait, 1'b1);
    cycles(2);

    // R6 buffer read clears flag
    curReq = "R6";
    readBuf();
    check("R6", "rxIntFlag", rxIntFlag, 1'b0);

    // R5 rising edge ends break
    curReq = "R5";
    rxIn = 1'b1; cycles(2);
    check("R5", "armBit early", armBit, 1'b1);
    cycles(1);
    check("R5", "armBit", armBit, 1'b0);
    check("R5", "rxSuppress", rxSuppress, 1'b0);
    check("R5", "breakWait", breakWait, 1'b0);
    cycles(3);

    // R7 read in the same cycle as the wake event
    curReq = "R7";
    writeArm(1'b1);
    cycles(2);
    rxIn = 1'b0; cycles(2);
    readBuf();
    check("R7", "rxIntFlag", rxIntFlag, 1'b1);
    rxIn = 1'b1; cycles(4);
    readBuf();
    cycles(2);

    // R8 software clear during the break
    curReq = "R8";
    writeArm(1'b1);
    rxIn = 1'b0; cycles(4);
    writeArm(1'b0);
    check("R8", "armBit", armBit, 1'b0);
    check("R8", "rxSuppress", rxSuppress, 1'b0);
    check("R8", "breakWait", breakWait, 1'b0);
    rxIn = 1'b1; cycles(4);
    readBuf();
    cycles(2);

    // R9 clockless wake in sleep
    curReq = "R9";
    writeArm(1'b1);
    cycles(2);
    clkRun = 1'b0;
    sleepMode = 1'b1;
    #5 rxIn = 1'b0;
    #3;
    check("R9", "rxIntFlag no clock", rxIntFlag, 1'b1);
    check("R9", "breakWait no clock", breakWait, 1'b0);
    check("R9", "armBit no clock", armBit, 1'b1);
    #20;
    @(negedge clkRaw); #1;
    clkRun = 1'b1;
    sleepMode = 1'b0;
    cycles(4);
    check("R9", "breakWait", breakWait, 1'b1);
    check("R9", "rxIntFlag", rxIntFlag, 1'b1);
    curReq = "R5";
    rxIn = 1'b1; cycles(4);
    check("R5", "armBit after sleep", armBit, 1'b0);
    readBuf();
    cycles(3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule